// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home node for a small group of cached processors. For every memory block it keeps a directory entry: a stable state, the id of the processor holding a dirty copy, a bit-vector of processors holding clean copies, and the home copy of the block data. Processors send load-miss, store-miss and writeback requests on a request port. They send unblock messages and invalidation acknowledgements on a response port. The controller sends each coherence message to a destination mask that names only the processors that have to act. It never broadcasts.

A request that needs help from another processor puts the entry in a busy transient state. The entry stays busy until the requester sends its unblock message, and any later request to that block waits at the port in the meantime. Requests to other blocks go on as normal. A store miss to a block that other processors share invalidates those processors. The controller counts their acknowledgements and grants the data only after the last one arrives.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is Idle with no sharers and zero data, `msg_valid` is low and `req_ready` is high.
- R2: A load miss to an Idle or Shared block is answered with one DATA message (`msg_kind` 0) to the requester alone, carrying the home data. The message is valid in the cycle after the request is accepted. The requester joins the sharer set.
- R3: A load miss to a Modified block from a processor other than the owner sends one FWD_LOAD message (`msg_kind` 1) to the owner only, with `msg_reqr` set to the requester. The entry becomes busy.
- R4: While an entry is busy, `req_ready` is low for any request to that block. Requests to other blocks are still accepted and answered.
- R5: An unblock (`rsp_kind` 0) from the pending requester of a forwarded load writes `rsp_data` into the home copy. The entry becomes Shared, with sharers = previous owner plus requester.
- R6: A store miss to a Shared block with sharers other than the requester sends one INVAL message (`msg_kind` 3) to exactly those sharers. The requester is named in `msg_reqr`. Each acknowledgement (`rsp_kind` 1) is counted. The DATA grant to the requester goes out in the cycle after the last acknowledgement, and no message goes out before that.
- R7: A store miss to an Idle block, or to a Shared block whose only sharer is the requester, is granted DATA at once and the entry becomes busy. The requester's unblock makes it the sole owner in Modified.
- R8: A store miss to a Modified block from a non-owner sends one FWD_STORE message (`msg_kind` 2) to the owner only. After the requester's unblock, the requester is the owner.
- R9: A writeback (`req_kind` 2) from the owner of a Modified block stores `req_data` and returns the entry to Idle with an empty sharer set, sending no message. A writeback from any other processor changes nothing.
- R10: No message ever goes to a processor that holds no copy, and forwards and invalidations never go to the requester. Non-DATA messages carry zero data. Request kinds are 0 load, 1 store, 2 writeback. Destination bit i means processor i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_kind | input | 2 | 0 load miss, 1 store miss, 2 writeback |
| req_src | input | PIDW | Requesting processor id |
| req_blk | input | BW | Block index |
| req_data | input | DW | Writeback data |
| rsp_valid | input | 1 | Response present, always accepted |
| rsp_kind | input | 1 | 0 unblock, 1 invalidation acknowledgement |
| rsp_src | input | PIDW | Sending processor id |
| rsp_blk | input | BW | Block index |
| rsp_data | input | DW | Block data carried by an unblock |
| msg_valid | output | 1 | Outgoing message valid for one cycle |
| msg_kind | output | 2 | 0 DATA, 1 FWD_LOAD, 2 FWD_STORE, 3 INVAL |
| msg_dst | output | NPROC | Destination processor mask |
| msg_reqr | output | PIDW | Original requester id |
| msg_blk | output | BW | Block index |
| msg_data | output | DW | Block data for DATA, zero otherwise |

## Verification
A corrupted sharer vector shows up as a wrong INVAL mask on the next store miss to that block. A corrupted owner field shows up as a forward sent to the wrong processor on the next load or store. Both appear in the cycle after that request is accepted. A miscounted acknowledgement shows up as a DATA grant that comes one acknowledgement early, or that never comes. A busy flag that clears too soon lets a second request be accepted when it should stall, and that request then gets an answer the scoreboard does not expect. Wrong home data stays hidden until the next DATA reply from the directory.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;

  typedef enum logic [1:0] {
    BLK_IDLE = 2'd0,
    BLK_SHRD = 2'd1,
    BLK_MOD  = 2'd2,
    BLK_BUSY = 2'd3
  } blk_state_e;

  typedef enum logic [1:0] {
    RQ_LOAD  = 2'd0,
    RQ_STORE = 2'd1,
    RQ_WBACK = 2'd2,
    RQ_NONE  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    MS_DATA      = 2'd0,
    MS_FWD_LOAD  = 2'd1,
    MS_FWD_STORE = 2'd2,
    MS_INVAL     = 2'd3
  } msg_kind_e;

  localparam logic RSP_UNBLOCK = 1'b0;
  localparam logic RSP_ACK     = 1'b1;

  // number of set bits, used for the acknowledgement count
  function automatic int unsigned cnt_ones(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/dir_req_decide.sv
module dir_req_decide
  import dir_home_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int DW    = 16,
  parameter int PIDW  = 2,
  parameter int AW    = 3
) (
  input  blk_state_e       cur_state,
  input  logic [PIDW-1:0]  cur_owner,
  input  logic [NPROC-1:0] cur_shr,
  input  logic [DW-1:0]    cur_data,
  input  req_kind_e        kind,
  input  logic [PIDW-1:0]  src,
  input  logic [DW-1:0]    wdata,
  output blk_state_e       nxt_state,
  output logic [PIDW-1:0]  nxt_owner,
  output logic [NPROC-1:0] nxt_shr,
  output logic [DW-1:0]    nxt_data,
  output logic             set_pend,
  output logic             pend_store,
  output logic [AW-1:0]    pend_ack,
  output logic             emit,
  output msg_kind_e        m_kind,
  output logic [NPROC-1:0] m_dst,
  output logic [DW-1:0]    m_data
);

  logic [NPROC-1:0] src_bit, own_bit, others;

  always_comb begin
    src_bit = '0;
    src_bit[src] = 1'b1;
    own_bit = '0;
    own_bit[cur_owner] = 1'b1;
    others = (cur_state == BLK_SHRD) ? (cur_shr & ~src_bit) : '0;
  end

  always_comb begin
    nxt_state  = cur_state;
    nxt_owner  = cur_owner;
    nxt_shr    = cur_shr;
    nxt_data   = cur_data;
    set_pend   = 1'b0;
    pend_store = 1'b0;
    pend_ack   = '0;
    emit       = 1'b0;
    m_kind     = MS_DATA;
    m_dst      = '0;
    m_data     = '0;
    case (kind)
      RQ_LOAD: begin
        if (cur_state == BLK_MOD && cur_owner != src) begin
          emit      = 1'b1;
          m_kind    = MS_FWD_LOAD;
          m_dst     = own_bit;
          nxt_state = BLK_BUSY;
          set_pend  = 1'b1;
        end else begin
          emit   = 1'b1;
          m_dst  = src_bit;
          m_data = cur_data;
          if (cur_state != BLK_MOD) begin
            nxt_state = BLK_SHRD;
            nxt_shr   = cur_shr | src_bit;
          end
        end
      end
      RQ_STORE: begin
        emit       = 1'b1;
        set_pend   = 1'b1;
        pend_store = 1'b1;
        nxt_state  = BLK_BUSY;
        if (cur_state == BLK_MOD && cur_owner != src) begin
          m_kind = MS_FWD_STORE;
          m_dst  = own_bit;
        end else if (others != '0) begin
          m_kind   = MS_INVAL;
          m_dst    = others;
          pend_ack = AW'(cnt_ones(32'(others)));
        end else begin
          m_dst  = src_bit;
          m_data = cur_data;
        end
      end
      RQ_WBACK: begin
        if (cur_state == BLK_MOD && cur_owner == src) begin
          nxt_state = BLK_IDLE;
          nxt_shr   = '0;
          nxt_data  = wdata;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dir_rsp_merge.sv
module dir_rsp_merge
  import dir_home_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int DW    = 16,
  parameter int PIDW  = 2,
  parameter int AW    = 3
) (
  input  logic             valid,
  input  logic             is_ack,
  input  logic [PIDW-1:0]  src,
  input  logic [DW-1:0]    data,
  input  blk_state_e       cur_state,
  input  logic [PIDW-1:0]  cur_owner,
  input  logic [NPROC-1:0] cur_shr,
  input  logic [DW-1:0]    cur_data,
  input  logic [PIDW-1:0]  p_req,
  input  logic             p_store,
  input  logic [AW-1:0]    p_ack,
  output logic             wr,
  output blk_state_e       n_state,
  output logic [PIDW-1:0]  n_owner,
  output logic [NPROC-1:0] n_shr,
  output logic [DW-1:0]    n_data,
  output logic [AW-1:0]    n_ack,
  output logic             grant,
  output logic [NPROC-1:0] g_dst
);

  logic [NPROC-1:0] req_bit, own_bit;

  always_comb begin
    req_bit = '0;
    req_bit[p_req] = 1'b1;
    own_bit = '0;
    own_bit[cur_owner] = 1'b1;
  end

  always_comb begin
    wr      = valid && (cur_state == BLK_BUSY);
    n_state = cur_state;
    n_owner = cur_owner;
    n_shr   = cur_shr;
    n_data  = cur_data;
    n_ack   = p_ack;
    grant   = 1'b0;
    g_dst   = req_bit;
    if (wr) begin
      if (is_ack == RSP_ACK) begin
        if (p_ack != '0) begin
          n_ack = p_ack - AW'(1);
          grant = (p_ack == AW'(1));
        end
      end else if (p_ack == '0 && src == p_req) begin
        if (p_store) begin
          n_state = BLK_MOD;
          n_owner = src;
          n_shr   = '0;
        end else begin
          n_state = BLK_SHRD;
          n_shr   = own_bit | req_bit;
          n_data  = data;
        end
      end
    end
  end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_home_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 16,
  localparam int PIDW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [PIDW-1:0]  req_src,
  input  logic [BW-1:0]    req_blk,
  input  logic [DW-1:0]    req_data,
  input  logic             rsp_valid,
  input  logic             rsp_kind,
  input  logic [PIDW-1:0]  rsp_src,
  input  logic [BW-1:0]    rsp_blk,
  input  logic [DW-1:0]    rsp_data,
  output logic             msg_valid,
  output logic [1:0]       msg_kind,
  output logic [NPROC-1:0] msg_dst,
  output logic [PIDW-1:0]  msg_reqr,
  output logic [BW-1:0]    msg_blk,
  output logic [DW-1:0]    msg_data
);

  localparam int AW = PIDW + 1;

  blk_state_e       blk_st  [NBLK];
  logic [PIDW-1:0]  blk_own [NBLK];
  logic [NPROC-1:0] blk_shr [NBLK];
  logic [DW-1:0]    blk_dat [NBLK];
  logic [PIDW-1:0]  pnd_req [NBLK];
  logic             pnd_st  [NBLK];
  logic [AW-1:0]    pnd_ack [NBLK];

  // request path
  blk_state_e       rq_state;
  logic [PIDW-1:0]  rq_owner;
  logic [NPROC-1:0] rq_shr;
  logic [DW-1:0]    rq_data;
  logic             rq_set_pend, rq_pstore, rq_emit;
  logic [AW-1:0]    rq_pack;
  msg_kind_e        rq_mkind;
  logic [NPROC-1:0] rq_mdst;
  logic [DW-1:0]    rq_mdata;

  // response path
  logic             rs_wr, rs_grant;
  blk_state_e       rs_state;
  logic [PIDW-1:0]  rs_owner;
  logic [NPROC-1:0] rs_shr;
  logic [DW-1:0]    rs_data;
  logic [AW-1:0]    rs_ack;
  logic [NPROC-1:0] rs_gdst;

  // named events for the checker
  logic req_blocked, req_fire, grant_fire;

  assign req_blocked = (blk_st[req_blk] == BLK_BUSY);
  assign grant_fire  = rs_grant;
  assign req_ready   = !req_blocked && !rs_grant;
  assign req_fire    = req_valid && req_ready;

  dir_req_decide #(.NPROC(NPROC), .DW(DW), .PIDW(PIDW), .AW(AW)) u_decide (
    .cur_state (blk_st[req_blk]),
    .cur_owner (blk_own[req_blk]),
    .cur_shr   (blk_shr[req_blk]),
    .cur_data  (blk_dat[req_blk]),
    .kind      (req_kind_e'(req_kind)),
    .src       (req_src),
    .wdata     (req_data),
    .nxt_state (rq_state),
    .nxt_owner (rq_owner),
    .nxt_shr   (rq_shr),
    .nxt_data  (rq_data),
    .set_pend  (rq_set_pend),
    .pend_store(rq_pstore),
    .pend_ack  (rq_pack),
    .emit      (rq_emit),
    .m_kind    (rq_mkind),
    .m_dst     (rq_mdst),
    .m_data    (rq_mdata)
  );

  dir_rsp_merge #(.NPROC(NPROC), .DW(DW), .PIDW(PIDW), .AW(AW)) u_merge (
    .valid    (rsp_valid),
    .is_ack   (rsp_kind),
    .src      (rsp_src),
    .data     (rsp_data),
    .cur_state(blk_st[rsp_blk]),
    .cur_owner(blk_own[rsp_blk]),
    .cur_shr  (blk_shr[rsp_blk]),
    .cur_data (blk_dat[rsp_blk]),
    .p_req    (pnd_req[rsp_blk]),
    .p_store  (pnd_st[rsp_blk]),
    .p_ack    (pnd_ack[rsp_blk]),
    .wr       (rs_wr),
    .n_state  (rs_state),
    .n_owner  (rs_owner),
    .n_shr    (rs_shr),
    .n_data   (rs_data),
    .n_ack    (rs_ack),
    .grant    (rs_grant),
    .g_dst    (rs_gdst)
  );

  // A request only touches a block that is not busy and a response only a
  // busy one, so the two writes below never hit the same entry.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        blk_st[b]  <= BLK_IDLE;
        blk_own[b] <= '0;
        blk_shr[b] <= '0;
        blk_dat[b] <= '0;
        pnd_req[b] <= '0;
        pnd_st[b]  <= 1'b0;
        pnd_ack[b] <= '0;
      end
      msg_valid <= 1'b0;
      msg_kind  <= '0;
      msg_dst   <= '0;
      msg_reqr  <= '0;
      msg_blk   <= '0;
      msg_data  <= '0;
    end else begin
      if (req_fire) begin
        blk_st[req_blk]  <= rq_state;
        blk_own[req_blk] <= rq_owner;
        blk_shr[req_blk] <= rq_shr;
        blk_dat[req_blk] <= rq_data;
        if (rq_set_pend) begin
          pnd_req[req_blk] <= req_src;
          pnd_st[req_blk]  <= rq_pstore;
          pnd_ack[req_blk] <= rq_pack;
        end
      end
      if (rs_wr) begin
        blk_st[rsp_blk]  <= rs_state;
        blk_own[rsp_blk] <= rs_owner;
        blk_shr[rsp_blk] <= rs_shr;
        blk_dat[rsp_blk] <= rs_data;
        pnd_ack[rsp_blk] <= rs_ack;
      end
      msg_valid <= rs_grant || (req_fire && rq_emit);
      if (rs_grant) begin
        msg_kind <= MS_DATA;
        msg_dst  <= rs_gdst;
        msg_reqr <= pnd_req[rsp_blk];
        msg_blk  <= rsp_blk;
        msg_data <= blk_dat[rsp_blk];
      end else begin
        msg_kind <= rq_mkind;
        msg_dst  <= rq_mdst;
        msg_reqr <= req_src;
        msg_blk  <= req_blk;
        msg_data <= rq_mdata;
      end
    end
  end

endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int NPROC = 4,
  parameter int PIDW  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_blocked,
  input logic             req_fire,
  input logic             grant_fire,
  input logic             msg_valid,
  input logic [1:0]       msg_kind,
  input logic [NPROC-1:0] msg_dst,
  input logic [PIDW-1:0]  msg_reqr
);

  // R4
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_blocked |-> !req_ready);

  // R2
  data_single_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == 2'd0 |-> $countones(msg_dst) == 1);

  // R3
  fwd_single_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && (msg_kind == 2'd1 || msg_kind == 2'd2) |-> $countones(msg_dst) == 1);

  // R10
  no_self_notify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind != 2'd0 |-> msg_dst != '0 && !msg_dst[msg_reqr]);

  // R6
  msg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(req_fire || grant_fire));

endmodule

bind dir_home_ctrl dir_home_chk #(.NPROC(NPROC), .PIDW(PIDW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_blocked(req_blocked),
  .req_fire   (req_fire),
  .grant_fire (grant_fire),
  .msg_valid  (msg_valid),
  .msg_kind   (msg_kind),
  .msg_dst    (msg_dst),
  .msg_reqr   (msg_reqr)
);

// File: tb/dir_home_ctrl_test.sv
module dir_home_ctrl_test;

  localparam int NPROC = 4;
  localparam int NBLK  = 8;
  localparam int DW    = 16;
  localparam int PIDW  = 2;
  localparam int BW    = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [1:0]       req_kind = '0;
  logic [PIDW-1:0]  req_src = '0;
  logic [BW-1:0]    req_blk = '0;
  logic [DW-1:0]    req_data = '0;
  logic             rsp_valid = 1'b0;
  logic             rsp_kind = 1'b0;
  logic [PIDW-1:0]  rsp_src = '0;
  logic [BW-1:0]    rsp_blk = '0;
  logic [DW-1:0]    rsp_data = '0;
  logic             msg_valid;
  logic [1:0]       msg_kind;
  logic [NPROC-1:0] msg_dst;
  logic [PIDW-1:0]  msg_reqr;
  logic [BW-1:0]    msg_blk;
  logic [DW-1:0]    msg_data;

  dir_home_ctrl #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_src(rsp_src),
    .rsp_blk(rsp_blk), .rsp_data(rsp_data),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst),
    .msg_reqr(msg_reqr), .msg_blk(msg_blk), .msg_data(msg_data)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct packed {
    logic [1:0]       kind;
    logic [NPROC-1:0] dst;
    logic [PIDW-1:0]  reqr;
    logic [BW-1:0]    blk;
    logic [DW-1:0]    data;
  } exp_msg_t;

  exp_msg_t exp_q[$];
  string    tag_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [1:0] K_DATA = 2'd0, K_FLD = 2'd1, K_FST = 2'd2, K_INV = 2'd3;
  localparam logic [1:0] Q_LOAD = 2'd0, Q_STORE = 2'd1, Q_WB = 2'd2;

  task automatic check(input bit ok, input string rq, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", rq, got, exp);
    end
  endtask

  task automatic expect_msg(input logic [1:0] k, input logic [NPROC-1:0] d,
                            input int r, input int b, input logic [DW-1:0] v,
                            input string rq);
    exp_msg_t e;
    e.kind = k; e.dst = d; e.reqr = PIDW'(r); e.blk = BW'(b); e.data = v;
    exp_q.push_back(e);
    tag_q.push_back(rq);
  endtask

  task automatic send_req(input logic [1:0] k, input int s, input int b,
                          input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_src = PIDW'(s);
    req_blk = BW'(b); req_data = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_rsp(input logic k, input int s, input int b,
                          input logic [DW-1:0] d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_kind = k; rsp_src = PIDW'(s);
    rsp_blk = BW'(b); rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  // probe that a request to a busy block is held off, then withdraw it
  task automatic probe_stall(input logic [1:0] k, input int s, input int b);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_src = PIDW'(s); req_blk = BW'(b);
    #1;
    check(req_ready == 1'b0, "R4 stall on busy block", 64'(req_ready), 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && msg_valid) begin
      exp_msg_t got;
      got = {msg_kind, msg_dst, msg_reqr, msg_blk, msg_data};
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected message", 64'(got), 64'd0);
      end else begin
        exp_msg_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got == e, t, 64'(got), 64'(e));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    check(msg_valid == 1'b0, "R1 no message after reset", 64'(msg_valid), 64'd0);

    // R1 R2 loads to an Idle then Shared block
    expect_msg(K_DATA, 4'b0001, 0, 1, 16'h0000, "R1 R2 load idle block");
    send_req(Q_LOAD, 0, 1, '0);
    expect_msg(K_DATA, 4'b0010, 1, 1, 16'h0000, "R2 load shared block");
    send_req(Q_LOAD, 1, 1, '0);

    // R6 store to shared block with two other sharers
    expect_msg(K_INV, 4'b0011, 2, 1, 16'h0000, "R6 invalidate sharers");
    send_req(Q_STORE, 2, 1, '0);
    send_rsp(1'b1, 0, 1, '0);
    @(negedge clk);
    check(msg_valid == 1'b0, "R6 no grant before last ack", 64'(msg_valid), 64'd0);
    probe_stall(Q_LOAD, 3, 1);
    expect_msg(K_DATA, 4'b1000, 3, 2, 16'h0000, "R4 other block proceeds");
    send_req(Q_LOAD, 3, 2, '0);
    expect_msg(K_DATA, 4'b0100, 2, 1, 16'h0000, "R6 grant after last ack");
    send_rsp(1'b1, 1, 1, '0);
    send_rsp(1'b0, 2, 1, '0);

    // R3 forwarded load, then R5 unblock with data
    expect_msg(K_FLD, 4'b0100, 3, 1, 16'h0000, "R3 forward load to owner");
    send_req(Q_LOAD, 3, 1, '0);
    probe_stall(Q_STORE, 0, 1);
    send_rsp(1'b0, 3, 1, 16'hBEEF);
    expect_msg(K_INV, 4'b1100, 0, 1, 16'h0000, "R5 sharers old owner and requester");
    send_req(Q_STORE, 0, 1, '0);
    send_rsp(1'b1, 2, 1, '0);
    expect_msg(K_DATA, 4'b0001, 0, 1, 16'hBEEF, "R5 home data updated");
    send_rsp(1'b1, 3, 1, '0);
    send_rsp(1'b0, 0, 1, '0);

    // R8 store to modified block
    expect_msg(K_FST, 4'b0001, 1, 1, 16'h0000, "R8 forward store to owner");
    send_req(Q_STORE, 1, 1, '0);
    send_rsp(1'b0, 1, 1, '0);

    // R9 writebacks: stale one ignored, owner one applied
    send_req(Q_WB, 3, 1, 16'h1234);
    send_req(Q_WB, 1, 1, 16'h5A5A);
    expect_msg(K_DATA, 4'b0100, 2, 1, 16'h5A5A, "R9 R7 store after writeback");
    send_req(Q_STORE, 2, 1, '0);
    send_rsp(1'b0, 2, 1, '0);
    expect_msg(K_FLD, 4'b0100, 0, 1, 16'h0000, "R7 requester became owner");
    send_req(Q_LOAD, 0, 1, '0);
    send_rsp(1'b0, 0, 1, 16'h0042);

    // R7 store by the only sharer
    expect_msg(K_DATA, 4'b0001, 0, 3, 16'h0000, "R2 load block 3");
    send_req(Q_LOAD, 0, 3, '0);
    expect_msg(K_DATA, 4'b0001, 0, 3, 16'h0000, "R7 sole sharer store granted");
    send_req(Q_STORE, 0, 3, '0);
    send_rsp(1'b0, 0, 3, '0);
    expect_msg(K_FLD, 4'b0001, 1, 3, 16'h0000, "R7 R10 owner only forwarded");
    send_req(Q_LOAD, 1, 3, '0);
    send_rsp(1'b0, 1, 3, 16'h0077);
    expect_msg(K_DATA, 4'b0100, 2, 3, 16'h0077, "R5 shared data reply");
    send_req(Q_LOAD, 2, 3, '0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 all expected messages seen",
          64'(exp_q.size()), 64'd0);
    finish_run();
  end

endmodule